// File: doc/BRIEF.md
# Serial Receiver with Break Detection

This block receives asynchronous serial characters on a single input line and queues them for a host. The line is brought into the clock domain through a flop chain, then watched by a state machine that advances on an external oversampling strobe at sixteen strobes per bit. Each character is eight data bits, least significant bit first, framed by one start bit and one stop bit. When a stop bit is sampled, the character goes into a four-entry queue together with a framing-error flag and a break flag.

A break is a character whose stop bit is low and whose data bits are all zero. It sets a sticky status bit and stops the receiver from taking any new start bit until the line has been seen high again. An arrival that finds the queue full sets a sticky overrun flag and is dropped. A break that arrives this way is dropped too. An optional start-bit interrupt can be armed. It rises in the same cycle that the idle receiver sees the line low. Only a write of zero to the arming bit clears it.

The host side is a small set of strobes and levels. These are the arm/disarm write, the error-flag clear, the queue pop, the head-of-queue fields, the data-ready flag and a live copy of the raw line.

Top module: `uart_rx_brk`

## Requirements
- R1: `rx_level_o` always equals `rx_i`, in reset and out of it, whatever the receiver state.
- R2: With `os_tick_i` high, a frame is a low start bit, 8 data bits with bit 0 first, and a stop bit. Each bit lasts 16 strobes. A frame with a high stop bit is queued with its data, `rd_ferr_o`=0 and `rd_brk_o`=0.
- R3: With the arming bit set, `irq_o` goes high in the cycle that the idle receiver sees the synchronized line low. It stays high until it is cleared. With the arming bit clear, `irq_o` stays low.
- R4: For a character received while armed, `irq_o` is high before `rdrf_o` rises for that character. `rdrf_o` rises once the stop bit has been sampled at its middle.
- R5: Writing 0 (`sie_we_i`=1, `sie_wdata_i`=0) disarms and clears a pending `irq_o` by the next cycle. Writing 1 leaves a pending request unchanged.
- R6: A stop bit sampled low with nonzero data is queued with `rd_ferr_o`=1 and `rd_brk_o`=0. It does not set `brk_o`.
- R7: A stop bit sampled low with all-zero data is a break. It is queued as data 0 with `rd_ferr_o`=1 and `rd_brk_o`=1, and it sets `brk_o`.
- R8: After a break, no start bit is accepted while the synchronized line stays low. Only one entry is queued, however long the line is held low.
- R9: `brk_o` and `ovr_o` stay set until a one-cycle pulse on `err_clr_i` clears them.
- R10: A character, or a break, that completes while the queue is full and no pop is taking place in that cycle sets `ovr_o`. It is discarded, and the queued entries are unchanged. A pop in the same cycle makes room, and no overrun occurs.
- R11: A start bit that is no longer low at its middle sample is abandoned, and nothing is queued.
- R12: The queue holds 4 entries in arrival order. `rdrf_o` is 1 while the queue is non-empty. The `rd_*` outputs show the oldest entry. `rd_en_i` removes that entry and has no effect when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| os_tick_i | input | 1 | Oversampling strobe, 16 per bit |
| sie_we_i | input | 1 | Write strobe for the start-interrupt arming bit |
| sie_wdata_i | input | 1 | Value written to the arming bit |
| err_clr_i | input | 1 | Clears break and overrun status |
| rd_en_i | input | 1 | Pops the oldest queued entry |
| rx_level_o | output | 1 | Live copy of the raw line |
| irq_o | output | 1 | Start-bit interrupt request |
| rdrf_o | output | 1 | Queue holds at least one entry |
| rd_data_o | output | 8 | Data of the oldest entry |
| rd_ferr_o | output | 1 | Framing-error flag of the oldest entry |
| rd_brk_o | output | 1 | Break flag of the oldest entry |
| brk_o | output | 1 | Sticky break-detected status |
| ovr_o | output | 1 | Sticky overrun status |

## Verification
The sharp collision is between queue insertion and the host pop. The bench fills all four entries, then times a one-cycle `rd_en_i` to hit the exact clock edge at which the fifth character is written. It finds that edge by counting the synchronizer stages, the sixteen-strobe bit cells and the registered insertion request. The bench then expects no overrun, and expects the queue to hold the second through fifth characters in order. A separate test lets a break land on a full queue with no pop. That test judges that the overrun flag is set, that the stored entries are intact, and that the break status is still set.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int RX_DATA_W = 8;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_START,
    RS_DATA,
    RS_STOP,
    RS_HOLD
  } rx_state_e;

  typedef struct packed {
    logic                 brk;
    logic                 ferr;
    logic [RX_DATA_W-1:0] data;
  } rx_entry_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick_i,
  input  logic      rx_s_i,
  output logic      start_det_o,
  output logic      push_o,
  output rx_entry_t entry_o,
  output logic      brk_evt_o
);

  localparam int CNT_W = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int BIT_W = $clog2(RX_DATA_W);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(RX_DATA_W - 1);

  rx_state_e              state_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [BIT_W-1:0]       bit_q;
  logic [RX_DATA_W-1:0]   shreg_q;
  logic                   stop_low;
  logic                   is_break;

  assign start_det_o = (state_q == RS_IDLE) && !rx_s_i;
  assign stop_low    = !rx_s_i;
  assign is_break    = stop_low && (shreg_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= RS_IDLE;
      cnt_q     <= '0;
      bit_q     <= '0;
      shreg_q   <= '0;
      push_o    <= 1'b0;
      entry_o   <= '0;
      brk_evt_o <= 1'b0;
    end else begin
      push_o    <= 1'b0;
      brk_evt_o <= 1'b0;
      unique case (state_q)
        RS_IDLE: begin
          if (!rx_s_i) begin
            state_q <= RS_START;
            cnt_q   <= '0;
          end
        end
        RS_START: begin
          if (tick_i) begin
            if (cnt_q == MID_CNT) begin
              cnt_q <= '0;
              bit_q <= '0;
              state_q <= rx_s_i ? RS_IDLE : RS_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        RS_DATA: begin
          if (tick_i) begin
            if (cnt_q == LAST_CNT) begin
              cnt_q   <= '0;
              shreg_q <= {rx_s_i, shreg_q[RX_DATA_W-1:1]};
              if (bit_q == LAST_BIT) state_q <= RS_STOP;
              else                   bit_q   <= bit_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        RS_STOP: begin
          if (tick_i) begin
            if (cnt_q == LAST_CNT) begin
              cnt_q         <= '0;
              push_o        <= 1'b1;
              entry_o.data  <= shreg_q;
              entry_o.ferr  <= stop_low;
              entry_o.brk   <= is_break;
              brk_evt_o     <= is_break;
              state_q       <= is_break ? RS_HOLD : RS_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        RS_HOLD: begin
          if (rx_s_i) state_q <= RS_IDLE;
        end
        default: state_q <= RS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             empty_o,
  output logic             full_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             do_wr, do_rd;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == FULL_CNT);
  assign do_rd   = rd_en_i && !empty_o;
  assign do_wr   = wr_en_i && (!full_o || do_rd);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr_q] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_wr) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (do_rd) rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_i,
  input  logic                 os_tick_i,
  input  logic                 sie_we_i,
  input  logic                 sie_wdata_i,
  input  logic                 err_clr_i,
  input  logic                 rd_en_i,
  output logic                 rx_level_o,
  output logic                 irq_o,
  output logic                 rdrf_o,
  output logic [RX_DATA_W-1:0] rd_data_o,
  output logic                 rd_ferr_o,
  output logic                 rd_brk_o,
  output logic                 brk_o,
  output logic                 ovr_o
);

  localparam int ENTRY_W = $bits(rx_entry_t);

  logic      rx_s;
  logic      start_det;
  logic      push;
  logic      brk_evt;
  rx_entry_t entry;
  rx_entry_t head;
  logic      fifo_empty, fifo_full;
  logic      arm_q, pend_q;
  logic      disarm;
  logic      overrun_evt;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (rx_i),
    .q_o (rx_s)
  );

  uart_rx_core #(.OSR(OSR)) u_core (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (os_tick_i),
    .rx_s_i      (rx_s),
    .start_det_o (start_det),
    .push_o      (push),
    .entry_o     (entry),
    .brk_evt_o   (brk_evt)
  );

  uart_rx_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (push),
    .wr_data_i (entry),
    .rd_en_i   (rd_en_i),
    .rd_data_o (head),
    .empty_o   (fifo_empty),
    .full_o    (fifo_full)
  );

  assign overrun_evt = push && fifo_full && !rd_en_i;
  assign disarm      = sie_we_i && !sie_wdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q  <= 1'b0;
      pend_q <= 1'b0;
      brk_o  <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      if (sie_we_i) arm_q <= sie_wdata_i;
      if (disarm)                      pend_q <= 1'b0;
      else if (arm_q && start_det)     pend_q <= 1'b1;
      if (brk_evt)        brk_o <= 1'b1;
      else if (err_clr_i) brk_o <= 1'b0;
      if (overrun_evt)    ovr_o <= 1'b1;
      else if (err_clr_i) ovr_o <= 1'b0;
    end
  end

  assign irq_o      = arm_q && (pend_q || start_det);
  assign rx_level_o = rx_i;
  assign rdrf_o     = !fifo_empty;
  assign rd_data_o  = head.data;
  assign rd_ferr_o  = head.ferr;
  assign rd_brk_o   = head.brk;

endmodule

// File: rtl/uart_rx_brk_chk.sv
module uart_rx_brk_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_i,
  input logic       sie_we_i,
  input logic       sie_wdata_i,
  input logic       err_clr_i,
  input logic       rd_en_i,
  input logic       rx_level_o,
  input logic       irq_o,
  input logic       rdrf_o,
  input logic [7:0] rd_data_o,
  input logic       rd_ferr_o,
  input logic       rd_brk_o,
  input logic       brk_o,
  input logic       ovr_o
);

  p_live_r1: assert property (@(posedge clk) rx_level_o == rx_i);

  p_irq_hold_r3: assert property (@(posedge clk) disable iff (rst)
    irq_o && !(sie_we_i && !sie_wdata_i) |=> irq_o);

  p_irq_clear_r5: assert property (@(posedge clk) disable iff (rst)
    sie_we_i && !sie_wdata_i |=> !irq_o);

  p_brk_entry_r7: assert property (@(posedge clk) disable iff (rst)
    rdrf_o && rd_brk_o |-> rd_ferr_o && (rd_data_o == 8'h00));

  p_brk_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    brk_o && !err_clr_i |=> brk_o);

  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    ovr_o && !err_clr_i |=> ovr_o);

  p_rdrf_hold_r12: assert property (@(posedge clk) disable iff (rst)
    rdrf_o && !rd_en_i |=> rdrf_o);

endmodule

bind uart_rx_brk uart_rx_brk_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_i        (rx_i),
  .sie_we_i    (sie_we_i),
  .sie_wdata_i (sie_wdata_i),
  .err_clr_i   (err_clr_i),
  .rd_en_i     (rd_en_i),
  .rx_level_o  (rx_level_o),
  .irq_o       (irq_o),
  .rdrf_o      (rdrf_o),
  .rd_data_o   (rd_data_o),
  .rd_ferr_o   (rd_ferr_o),
  .rd_brk_o    (rd_brk_o),
  .brk_o       (brk_o),
  .ovr_o       (ovr_o)
);

// File: tb/uart_rx_brk_tb.sv
module uart_rx_brk_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_i = 1'b1;
  logic       os_tick_i = 1'b1;
  logic       sie_we_i = 1'b0;
  logic       sie_wdata_i = 1'b0;
  logic       err_clr_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic       rx_level_o, irq_o, rdrf_o, rd_ferr_o, rd_brk_o, brk_o, ovr_o;
  logic [7:0] rd_data_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  uart_rx_brk u_dut (
    .clk         (clk),
    .rst         (rst),
    .rx_i        (rx_i),
    .os_tick_i   (os_tick_i),
    .sie_we_i    (sie_we_i),
    .sie_wdata_i (sie_wdata_i),
    .err_clr_i   (err_clr_i),
    .rd_en_i     (rd_en_i),
    .rx_level_o  (rx_level_o),
    .irq_o       (irq_o),
    .rdrf_o      (rdrf_o),
    .rd_data_o   (rd_data_o),
    .rd_ferr_o   (rd_ferr_o),
    .rd_brk_o    (rd_brk_o),
    .brk_o       (brk_o),
    .ovr_o       (ovr_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stop);
    @(negedge clk) rx_i = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_i = d[i];
      repeat (16) @(negedge clk);
    end
    rx_i = stop;
    repeat (16) @(negedge clk);
    rx_i = 1'b1;
  endtask

  task automatic pop_check(input string req, input logic [7:0] d, input logic fe, input logic bk);
    check({req, " rdrf"}, rdrf_o, 1);
    check({req, " data"}, rd_data_o, d);
    check({req, " ferr"}, rd_ferr_o, fe);
    check({req, " brk"}, rd_brk_o, bk);
    @(negedge clk) rd_en_i = 1'b1;
    @(negedge clk) rd_en_i = 1'b0;
  endtask

  task automatic sie_write(input logic b);
    @(negedge clk) begin sie_we_i = 1'b1; sie_wdata_i = b; end
    @(negedge clk) sie_we_i = 1'b0;
  endtask

  task automatic err_clear();
    @(negedge clk) err_clr_i = 1'b1;
    @(negedge clk) err_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle(3);
    rx_i = 1'b0; #1;
    check("R1 live low in reset", rx_level_o, 0);
    rx_i = 1'b1; #1;
    check("R1 live high in reset", rx_level_o, 1);
    check("R12 reset rdrf", rdrf_o, 0);
    check("R3 reset irq", irq_o, 0);
    check("R9 reset brk", brk_o, 0);
    check("R9 reset ovr", ovr_o, 0);
    @(negedge clk) rst = 1'b0;
    idle(4);
  endtask

  task automatic t_plain();
    send_frame(8'hA5, 1'b1);
    idle(4);
    check("R3 no irq when disarmed", irq_o, 0);
    pop_check("R2 plain", 8'hA5, 1'b0, 1'b0);
    check("R12 empty after pop", rdrf_o, 0);
    @(negedge clk) rd_en_i = 1'b1;
    @(negedge clk) rd_en_i = 1'b0;
    check("R12 pop on empty", rdrf_o, 0);
    check("R1 live idle", rx_level_o, 1);
  endtask

  task automatic t_irq();
    sie_write(1'b1);
    fork
      send_frame(8'h3C, 1'b1);
      begin
        @(negedge clk);
        @(negedge clk);
        check("R3 irq not before sync", irq_o, 0);
        @(negedge clk);
        check("R3 irq on start", irq_o, 1);
        check("R4 rdrf still low", rdrf_o, 0);
      end
    join
    idle(4);
    check("R4 rdrf after stop", rdrf_o, 1);
    check("R3 irq held", irq_o, 1);
    sie_write(1'b1);
    check("R5 write one keeps irq", irq_o, 1);
    sie_write(1'b0);
    check("R5 write zero clears irq", irq_o, 0);
    pop_check("R2 irq char", 8'h3C, 1'b0, 1'b0);
  endtask

  task automatic t_ferr();
    send_frame(8'h3C, 1'b0);
    idle(40);
    pop_check("R6 framing", 8'h3C, 1'b1, 1'b0);
    check("R6 brk untouched", brk_o, 0);
    check("R11 no stray entry", rdrf_o, 0);
  endtask

  task automatic t_break_hold();
    @(negedge clk) rx_i = 1'b0;
    repeat (160 + 640) @(negedge clk);
    rx_i = 1'b1;
    idle(40);
    check("R7 brk status", brk_o, 1);
    pop_check("R7 break entry", 8'h00, 1'b1, 1'b1);
    check("R8 single entry", rdrf_o, 0);
  endtask

  task automatic t_sticky();
    send_frame(8'h5A, 1'b1);
    idle(4);
    check("R9 brk stays", brk_o, 1);
    pop_check("R2 after break", 8'h5A, 1'b0, 1'b0);
    err_clear();
    check("R9 brk cleared", brk_o, 0);
  endtask

  task automatic t_glitch();
    @(negedge clk) rx_i = 1'b0;
    idle(5);
    rx_i = 1'b1;
    idle(60);
    check("R11 glitch ignored", rdrf_o, 0);
  endtask

  task automatic t_full_break();
    send_frame(8'h11, 1'b1);
    send_frame(8'h22, 1'b1);
    send_frame(8'h33, 1'b1);
    send_frame(8'h44, 1'b1);
    check("R10 no ovr yet", ovr_o, 0);
    send_frame(8'h00, 1'b0);
    idle(20);
    check("R10 ovr on full break", ovr_o, 1);
    check("R7 brk on dropped break", brk_o, 1);
    pop_check("R12 order 1", 8'h11, 1'b0, 1'b0);
    pop_check("R12 order 2", 8'h22, 1'b0, 1'b0);
    pop_check("R12 order 3", 8'h33, 1'b0, 1'b0);
    pop_check("R10 kept 4", 8'h44, 1'b0, 1'b0);
    check("R10 break dropped", rdrf_o, 0);
    err_clear();
    check("R9 ovr cleared", ovr_o, 0);
    check("R9 brk cleared again", brk_o, 0);
  endtask

  task automatic t_collide();
    send_frame(8'h01, 1'b1);
    send_frame(8'h02, 1'b1);
    send_frame(8'h03, 1'b1);
    send_frame(8'h04, 1'b1);
    fork
      send_frame(8'h77, 1'b1);
      begin
        @(negedge clk);
        repeat (155) @(negedge clk);
        rd_en_i = 1'b1;
        @(negedge clk) rd_en_i = 1'b0;
      end
    join
    idle(4);
    check("R10 no ovr on push with pop", ovr_o, 0);
    pop_check("R12 collide 1", 8'h02, 1'b0, 1'b0);
    pop_check("R12 collide 2", 8'h03, 1'b0, 1'b0);
    pop_check("R12 collide 3", 8'h04, 1'b0, 1'b0);
    pop_check("R10 collide new", 8'h77, 1'b0, 1'b0);
    check("R12 drained", rdrf_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_plain();
    t_irq();
    t_ferr();
    t_break_hold();
    t_sticky();
    t_glitch();
    t_full_break();
    t_collide();
    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule